// File: doc/BRIEF.md
# Big-Endian Load/Store Alignment Unit

This block sits between a word-wide data memory and the register file of a simple load/store processor. The address adder has already produced an effective address. The unit turns it into a word-aligned memory address, picks the byte lanes for a byte, halfword or word access, and places store data on those lanes with matching byte-write enables. On a load, it takes the addressed byte or halfword out of the word read from memory and extends it to a full register value, either with the sign bit or with zeros.

Lanes are numbered in big-endian order. Offset 0 inside a word is the most significant byte, bits 31:24. A halfword or word access whose address does not match its size is flagged. Such an access writes nothing and returns zero. Size code 11 is reserved and is handled the same way. The unit is purely combinational and has no clock or reset.

Top module: `lsu_align_top`

## Requirements
- R1: `memAddr` equals `effAddr` with bits 1:0 forced to zero, for every access.
- R2: Byte offset k (effAddr[1:0]) maps to data bits [31-8k : 24-8k] and to `byteWe[3-k]`. Offset 0 is the most significant byte.
- R3: When `loadUnsigned` is 0, a byte or halfword load copies the top bit of the selected field into every higher result bit.
- R4: When `loadUnsigned` is 1, a byte or halfword load fills every higher result bit with zero.
- R5: A halfword read at offset 0 returns bits 31:16 and at offset 2 returns bits 15:0. A word read returns the whole word. `loadResult` is produced for every aligned access, stores included.
- R6: A byte store (`isStore`=1, `accSize`=00) drives storeData[7:0] onto the addressed lane. A halfword store (`accSize`=01) drives storeData[15:8] onto the lower-offset lane and storeData[7:0] onto the next one. Only those lanes have their enable set, and every other lane of `memWdata` is zero.
- R7: A word store (`accSize`=10) at offset 0 sets all four enables and drives `storeData` unchanged.
- R8: A byte access is never misaligned. A halfword access is misaligned when effAddr[0] is 1. A word access is misaligned when effAddr[1:0] is not 00.
- R9: While `misaligned` is 1, `byteWe`, `memWdata` and `loadResult` are all zero.
- R10: When `isStore` is 0, `byteWe` is zero for every size and offset.
- R11: Size code 11 is illegal. It raises `misaligned` and is suppressed as in R9, for loads and for stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| effAddr | input | 32 | Effective byte address |
| accSize | input | 2 | Access size: 00 byte, 01 halfword, 10 word, 11 reserved |
| loadUnsigned | input | 1 | 1 selects zero extension, 0 selects sign extension |
| isStore | input | 1 | 1 for a store, 0 for a load |
| storeData | input | 32 | Store source register value |
| memRdata | input | 32 | Word read from memory at `memAddr` |
| memAddr | output | 32 | Word-aligned memory address |
| byteWe | output | 4 | Byte-write enables; bit i enables data bits 8i+7:8i |
| memWdata | output | 32 | Store data placed on its byte lanes |
| loadResult | output | 32 | Extended load value |
| misaligned | output | 1 | Access does not match its size alignment, or size is reserved |

## Verification
The vector table reads one word, 0xABCD1234, through every size and offset. A wrong lane choice therefore shows up as a different byte value, which separates big-endian from little-endian mapping. A second word with the top bit set in each byte separates sign extension from zero extension. Stores use source data 0xDEADBEEF, whose four bytes all differ. This shows whether the low bits or the high bits of the source land on a lane, and whether a halfword store puts its two bytes in the right order. Sweeps over all offsets and sizes then separate accesses that are legal from those that are misaligned or use the reserved size, and separate loads from stores for the write enables.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
  localparam int BYTE_W = 8;
  localparam int LANES  = 4;
  localparam int DATA_W = BYTE_W * LANES;
  localparam int HALF_W = 2 * BYTE_W;
  localparam int OFF_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } accSize_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic              misaligned;
    logic [LANES-1:0]  laneEn;
    logic [LANES-1:0]  wrEn;
    logic              signExt;
    accSize_e          size;
    logic [OFF_W-1:0]  offset;
  } ctlStrobe_t;
endpackage

// File: rtl/lsu_align_ctrl.sv
module lsu_align_ctrl
  import lsu_align_pkg::*;
(
  input  logic [OFF_W-1:0] offset,
  input  accSize_e         size,
  input  logic             loadUnsigned,
  input  logic             isStore,
  output ctlStrobe_t       ctl
);
  logic [OFF_W-1:0] topLane;
  logic             aligned;
  logic [LANES-1:0] laneEn;

  // Big-endian: offset 0 is the highest lane
  assign topLane = OFF_W'(LANES - 1) - offset;

  always_comb begin
    aligned = 1'b0;
    laneEn  = '0;
    case (size)
      SZ_BYTE: begin
        aligned = 1'b1;
        laneEn  = LANES'(1) << topLane;
      end
      SZ_HALF: begin
        aligned = ~offset[0];
        if (aligned) laneEn = LANES'(3) << (topLane - OFF_W'(1));
      end
      SZ_WORD: begin
        aligned = (offset == '0);
        if (aligned) laneEn = '1;
      end
      default: aligned = 1'b0;
    endcase
  end

  assign ctl.misaligned = ~aligned;
  assign ctl.laneEn     = laneEn;
  assign ctl.wrEn       = laneEn & {LANES{isStore & aligned}};
  assign ctl.signExt    = ~loadUnsigned;
  assign ctl.size       = size;
  assign ctl.offset     = offset;

  always_comb begin
    if (size == SZ_BYTE)
      a_r8_byte_always_aligned: assert (!ctl.misaligned);
    if (!isStore)
      a_r10_load_no_write: assert (ctl.wrEn == '0);
    if (!ctl.misaligned && size == SZ_HALF)
      a_r6_half_two_lanes: assert ($countones(ctl.laneEn) == 2);
    if (!ctl.misaligned && size == SZ_BYTE)
      a_r2_byte_one_lane: assert ($countones(ctl.laneEn) == 1);
  end
endmodule

// File: rtl/lsu_align_dpath.sv
module lsu_align_dpath
  import lsu_align_pkg::*;
(
  input  ctlStrobe_t         ctl,
  input  logic [DATA_W-1:0]  storeData,
  input  logic [DATA_W-1:0]  memRdata,
  output logic [LANES-1:0]   byteWe,
  output logic [DATA_W-1:0]  memWdata,
  output logic [DATA_W-1:0]  loadResult
);
  localparam int EXT_B = DATA_W - BYTE_W;
  localparam int EXT_H = DATA_W - HALF_W;

  logic [OFF_W-1:0]  topLane;
  logic [BYTE_W-1:0] byteVal;
  logic [HALF_W-1:0] halfVal;

  assign topLane = OFF_W'(LANES - 1) - ctl.offset;

  // Field extraction from the read word
  always_comb begin
    byteVal = '0;
    halfVal = '0;
    for (int i = 0; i < LANES; i++)
      if (OFF_W'(i) == topLane) byteVal = memRdata[BYTE_W*i +: BYTE_W];
    for (int i = 0; i < LANES/2; i++)
      if (OFF_W'(2*i + 1) == topLane) halfVal = memRdata[HALF_W*i +: HALF_W];
  end

  always_comb begin
    loadResult = '0;
    if (!ctl.misaligned) begin
      case (ctl.size)
        SZ_BYTE: loadResult = {{EXT_B{ctl.signExt & byteVal[BYTE_W-1]}}, byteVal};
        SZ_HALF: loadResult = {{EXT_H{ctl.signExt & halfVal[HALF_W-1]}}, halfVal};
        SZ_WORD: loadResult = memRdata;
        default: loadResult = '0;
      endcase
    end
  end

  // Store lane steering
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] laneData;
    always_comb begin
      laneData = '0;
      if (ctl.wrEn[g]) begin
        case (ctl.size)
          SZ_BYTE: laneData = storeData[BYTE_W-1:0];
          SZ_HALF: laneData = (OFF_W'(g) == topLane) ? storeData[HALF_W-1:BYTE_W]
                                                     : storeData[BYTE_W-1:0];
          SZ_WORD: laneData = storeData[BYTE_W*g +: BYTE_W];
          default: laneData = '0;
        endcase
      end
    end
    assign memWdata[BYTE_W*g +: BYTE_W] = laneData;
  end

  assign byteWe = ctl.wrEn;

  always_comb begin
    if (ctl.misaligned)
      a_r9_quiet_on_misalign: assert (loadResult == '0 && memWdata == '0);
    if (!ctl.misaligned && ctl.size == SZ_BYTE && !ctl.signExt)
      a_r4_byte_zero_ext: assert (loadResult[DATA_W-1:BYTE_W] == '0);
    if (!ctl.misaligned && ctl.size == SZ_HALF && !ctl.signExt)
      a_r4_half_zero_ext: assert (loadResult[DATA_W-1:HALF_W] == '0);
  end
endmodule

// File: rtl/lsu_align_top.sv
module lsu_align_top
  import lsu_align_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] effAddr,
  input  logic [1:0]        accSize,
  input  logic              loadUnsigned,
  input  logic              isStore,
  input  logic [DATA_W-1:0] storeData,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LANES-1:0]  byteWe,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] loadResult,
  output logic              misaligned
);
  ctlStrobe_t ctl;

  lsu_align_ctrl ctrl_i (
    .offset       (effAddr[OFF_W-1:0]),
    .size         (accSize_e'(accSize)),
    .loadUnsigned (loadUnsigned),
    .isStore      (isStore),
    .ctl          (ctl)
  );

  lsu_align_dpath dpath_i (
    .ctl        (ctl),
    .storeData  (storeData),
    .memRdata   (memRdata),
    .byteWe     (byteWe),
    .memWdata   (memWdata),
    .loadResult (loadResult)
  );

  assign memAddr    = {effAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign misaligned = ctl.misaligned;

  always_comb begin
    if (misaligned)
      a_r9_no_enable_on_misalign: assert (byteWe == '0);
    if (byteWe == '1)
      a_r7_word_passthrough: assert (memWdata == storeData);
    if (accSize == 2'b11)
      a_r11_reserved_flagged: assert (misaligned && byteWe == '0);
  end
endmodule

// File: tb/lsu_align_tb.sv
module lsu_align_top_tb_top;
  logic        clk = 1'b0;
  logic [31:0] effAddr = '0;
  logic [1:0]  accSize = '0;
  logic        loadUnsigned = 1'b0;
  logic        isStore = 1'b0;
  logic [31:0] storeData = '0;
  logic [31:0] memRdata = '0;
  logic [31:0] memAddr;
  logic [3:0]  byteWe;
  logic [31:0] memWdata;
  logic [31:0] loadResult;
  logic        misaligned;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lsu_align_top dut_i (
    .effAddr(effAddr), .accSize(accSize), .loadUnsigned(loadUnsigned),
    .isStore(isStore), .storeData(storeData), .memRdata(memRdata),
    .memAddr(memAddr), .byteWe(byteWe), .memWdata(memWdata),
    .loadResult(loadResult), .misaligned(misaligned)
  );

  typedef struct packed {
    logic [31:0] addr; logic [1:0] sz; logic uns; logic st;
    logic [31:0] sd; logic [31:0] rd;
    logic [3:0] we; logic [31:0] wd; logic [31:0] ld; logic mis;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{32'h1001, 2'b00, 1'b0, 1'b0, 32'hDEADBEEF, 32'hABCD1234, 4'h0, 32'h0, 32'hFFFFFFCD, 1'b0},
    '{32'h1000, 2'b00, 1'b1, 1'b0, 32'hDEADBEEF, 32'hABCD1234, 4'h0, 32'h0, 32'h000000AB, 1'b0},
    '{32'h1002, 2'b01, 1'b0, 1'b0, 32'hDEADBEEF, 32'hABCD1234, 4'h0, 32'h0, 32'h00001234, 1'b0},
    '{32'h1000, 2'b01, 1'b0, 1'b0, 32'hDEADBEEF, 32'hABCD1234, 4'h0, 32'h0, 32'hFFFFABCD, 1'b0},
    '{32'h1000, 2'b01, 1'b1, 1'b0, 32'hDEADBEEF, 32'hABCD1234, 4'h0, 32'h0, 32'h0000ABCD, 1'b0},
    '{32'h1000, 2'b10, 1'b0, 1'b0, 32'hDEADBEEF, 32'hABCD1234, 4'h0, 32'h0, 32'hABCD1234, 1'b0},
    '{32'h1003, 2'b00, 1'b0, 1'b0, 32'hDEADBEEF, 32'hABCD1234, 4'h0, 32'h0, 32'h00000034, 1'b0},
    '{32'h1000, 2'b01, 1'b0, 1'b1, 32'hDEADBEEF, 32'hABCD1234, 4'hC, 32'hBEEF0000, 32'hFFFFABCD, 1'b0},
    '{32'h1003, 2'b00, 1'b0, 1'b1, 32'hDEADBEEF, 32'hABCD1234, 4'h1, 32'h000000EF, 32'h00000034, 1'b0},
    '{32'h1000, 2'b10, 1'b0, 1'b1, 32'hDEADBEEF, 32'hABCD1234, 4'hF, 32'hDEADBEEF, 32'hABCD1234, 1'b0},
    '{32'h1001, 2'b01, 1'b0, 1'b0, 32'hDEADBEEF, 32'hABCD1234, 4'h0, 32'h0, 32'h0, 1'b1},
    '{32'h1002, 2'b10, 1'b0, 1'b1, 32'hDEADBEEF, 32'hABCD1234, 4'h0, 32'h0, 32'h0, 1'b1},
    '{32'h1002, 2'b01, 1'b0, 1'b1, 32'hDEADBEEF, 32'hABCD1234, 4'h3, 32'h0000BEEF, 32'h00001234, 1'b0},
    '{32'h1000, 2'b11, 1'b0, 1'b0, 32'hDEADBEEF, 32'hABCD1234, 4'h0, 32'h0, 32'h0, 1'b1},
    '{32'h1002, 2'b00, 1'b0, 1'b0, 32'hDEADBEEF, 32'h00FF8000, 4'h0, 32'h0, 32'hFFFFFF80, 1'b0},
    '{32'h1002, 2'b00, 1'b1, 1'b0, 32'hDEADBEEF, 32'h00FF8000, 4'h0, 32'h0, 32'h00000080, 1'b0},
    '{32'h1001, 2'b10, 1'b0, 1'b0, 32'hDEADBEEF, 32'hABCD1234, 4'h0, 32'h0, 32'h0, 1'b1},
    '{32'h1001, 2'b00, 1'b1, 1'b1, 32'hDEADBEEF, 32'hABCD1234, 4'h4, 32'h00EF0000, 32'h000000CD, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (addr=%h size=%b st=%b)",
               tag, act, exp, effAddr, accSize, isStore);
    end
  endtask

  task automatic drive(input logic [31:0] a, input logic [1:0] sz, input logic uns,
                       input logic st, input logic [31:0] sd, input logic [31:0] rd);
    @(negedge clk);
    effAddr = a; accSize = sz; loadUnsigned = uns; isStore = st;
    storeData = sd; memRdata = rd;
    #1;
  endtask

  initial begin
    // Idle state with all inputs zero
    #1;
    chk("R10 idle byteWe", {28'h0, byteWe}, 32'h0);
    chk("R8 idle misaligned", {31'h0, misaligned}, 32'h0);
    chk("R1 idle memAddr", memAddr, 32'h0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      drive(VECS[v].addr, VECS[v].sz, VECS[v].uns, VECS[v].st, VECS[v].sd, VECS[v].rd);
      chk("R1 memAddr", memAddr, VECS[v].addr & 32'hFFFFFFFC);
      chk("R6 byteWe", {28'h0, byteWe}, {28'h0, VECS[v].we});
      chk("R6 memWdata", memWdata, VECS[v].wd);
      chk("R5 loadResult", loadResult, VECS[v].ld);
      chk("R8 misaligned", {31'h0, misaligned}, {31'h0, VECS[v].mis});
    end

    // R2: byte store lane sweep
    for (int k = 0; k < 4; k++) begin
      drive(32'h2000 + k, 2'b00, 1'b0, 1'b1, 32'h000000A5, 32'h0);
      chk("R2 byte lane enable", {28'h0, byteWe}, 32'h1 << (3 - k));
      chk("R2 byte lane data", memWdata, 32'hA5 << (8 * (3 - k)));
    end

    // R3: signed byte loads, every byte has its top bit set
    for (int k = 0; k < 4; k++) begin
      drive(32'h3000 + k, 2'b00, 1'b0, 1'b0, 32'h0, 32'h80818283);
      chk("R3 sign extend byte", loadResult, 32'hFFFFFF80 | k);
    end
    drive(32'h3002, 2'b01, 1'b0, 1'b0, 32'h0, 32'h0000F00F);
    chk("R3 sign extend half", loadResult, 32'hFFFFF00F);

    // R4: unsigned halfword
    drive(32'h3000, 2'b01, 1'b1, 1'b0, 32'h0, 32'hF00F0000);
    chk("R4 zero extend half", loadResult, 32'h0000F00F);

    // R7: word store
    drive(32'h4000, 2'b10, 1'b1, 1'b1, 32'h13579BDF, 32'h0);
    chk("R7 word enables", {28'h0, byteWe}, 32'hF);
    chk("R7 word data", memWdata, 32'h13579BDF);

    // R9: misaligned half store is fully suppressed
    drive(32'h4003, 2'b01, 1'b0, 1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF);
    chk("R9 misaligned flag", {31'h0, misaligned}, 32'h1);
    chk("R9 no enables", {28'h0, byteWe}, 32'h0);
    chk("R9 no write data", memWdata, 32'h0);
    chk("R9 load zero", loadResult, 32'h0);

    // R10: loads never write, any size and offset
    for (int s = 0; s < 4; s++)
      for (int k = 0; k < 4; k++) begin
        drive(32'h5000 + k, s[1:0], 1'b0, 1'b0, 32'hFFFFFFFF, 32'h12345678);
        chk("R10 load no enable", {28'h0, byteWe}, 32'h0);
      end

    // R11: reserved size as a store
    drive(32'h6000, 2'b11, 1'b0, 1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF);
    chk("R11 reserved flag", {31'h0, misaligned}, 32'h1);
    chk("R11 reserved no enable", {28'h0, byteWe}, 32'h0);
    chk("R11 reserved load zero", loadResult, 32'h0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=timeout expected=complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule